// File: doc/BRIEF.md
# Banked External Memory Window

This block translates addresses from a CPU whose data space is 16 bits wide onto an external memory larger than that space. The upper half of the CPU space, 32 KB, is a window onto the external device. The CPU's top address bit does not reach the device. In its place, a bank register that software writes supplies the high external address bits. The default target is 512 KB, so the external address is 19 bits wide and the bank register holds 4 bits.

Accesses to the lower half of the CPU space are flagged for internal resources and never reach the external bus. An external write completes in the same cycle it is requested. An external read takes two cycles: the first raises a wait, and the CPU samples the data in the second. The address of a read is captured in its first cycle, so a bank change can only affect an access that starts later.

Top module: `bankwin_top`

## Requirements
- R1: After reset the bank register holds 0, the block is idle with `cpu_wait` low, and an access to CPU address 0x8000 drives external address 0.
- R2: When CPU address bit 15 is 1, `ext_addr` equals bank × 32768 plus CPU address bits 14:0, and `ext_sel` is high for the access.
- R3: When CPU address bit 15 is 0, any read or write raises `int_sel`, and `ext_sel`, `ext_rd` and `ext_wr` all stay low.
- R4: An external write raises `ext_sel` and `ext_wr` in the cycle it is requested, drives `cpu_wdata` onto `ext_wdata`, and never raises `cpu_wait`. If read and write are requested together, the write is performed.
- R5: An external read raises `ext_sel`, `ext_rd` and `cpu_wait` in its first cycle. In its second cycle `cpu_wait` is low, `ext_rd` stays high and `cpu_rdata` equals `ext_rdata`.
- R6: A bank write is used from the following cycle onwards. A bank write made during the first cycle of a read does not change the address used in that read's second cycle.
- R7: An external write made in the same cycle as a bank write uses the old bank value.
- R8: `cpu_rdata` is 0 in every cycle that is not the second cycle of an external read.
- R9: A read request still held after a read's second cycle starts a new two-cycle read, so a held request gives a wait pattern of 1, 0, 1, 0.
- R10: Bank 15 with CPU address 0xFFFF maps to the top external address 0x7FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU data address |
| cpu_rd | input | 1 | CPU read request |
| cpu_wr | input | 1 | CPU write request |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| cpu_wait | output | 1 | Stall request to the CPU |
| bank_we | input | 1 | Bank register write enable |
| bank_wdata | input | 4 | New bank number |
| int_sel | output | 1 | Access targets the internal region |
| ext_addr | output | 19 | External memory address |
| ext_sel | output | 1 | External chip select, active high |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| ext_wdata | output | 8 | External write data |
| ext_rdata | input | 8 | External read data |

## Verification
A wrong bank value appears on the upper `ext_addr` bits in the first external cycle after the fault, and data read back then differs from what the bench's memory model holds. A read sequencer stuck in, or skipping, its data phase shows up on `cpu_wait`, `ext_rd` or `cpu_rdata` in the very next cycle. A read address latched at the wrong time only shows once a bank change lands during the read's first cycle, and it then shows in the second cycle as a changed `ext_addr`.

// File: rtl/bankwin_pkg.sv
package bankwin_pkg;
  // read sequencer phase: idle/address cycle, or the data cycle of a read
  typedef enum logic {PH_IDLE = 1'b0, PH_DATA = 1'b1} phase_t;
endpackage

// File: rtl/bankwin_bank.sv
module bankwin_bank #(
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] bank_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  bank_q <= '0;
    else if (we) bank_q <= wdata;
  end

  // R6: bank only changes through a write, and takes the written value
  a_r6_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(bank_q));
  a_r6_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (bank_q == $past(wdata)));
endmodule

// File: rtl/bankwin_seq.sv
module bankwin_seq
  import bankwin_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_rd,
  output logic start_rd,
  output logic in_data
);
  phase_t phase, phase_nx;

  always_comb begin
    phase_nx = phase;
    case (phase)
      PH_IDLE: if (req_rd) phase_nx = PH_DATA;
      PH_DATA: phase_nx = PH_IDLE;
      default: phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nx;
  end

  assign start_rd = (phase == PH_IDLE) && req_rd;
  assign in_data  = (phase == PH_DATA);

  // R5: an address cycle is always followed by exactly one data cycle
  a_r5_data_follows: assert property (@(posedge clk) disable iff (!rst_n)
    start_rd |=> in_data);
  // R9: the data cycle never repeats
  a_r9_single_data: assert property (@(posedge clk) disable iff (!rst_n)
    in_data |=> !in_data);
endmodule

// File: rtl/bankwin_amux.sv
module bankwin_amux #(
  parameter int CPU_AW = 16,
  parameter int EXT_AW = 19
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CPU_AW-1:0]        cpu_addr,
  input  logic [EXT_AW-CPU_AW:0]   bank_q,
  input  logic                     start_rd,
  input  logic                     in_data,
  output logic [EXT_AW-1:0]        ext_addr
);
  localparam int OFF_W  = CPU_AW - 1;
  localparam int BANK_W = EXT_AW - OFF_W;

  // window offset with the bank number in place of the top CPU bit
  function automatic logic [EXT_AW-1:0] map_addr(input logic [BANK_W-1:0] b,
                                                 input logic [CPU_AW-1:0] a);
    return {b, a[OFF_W-1:0]};
  endfunction

  logic [EXT_AW-1:0] live_addr;
  logic [EXT_AW-1:0] held_addr;

  assign live_addr = map_addr(bank_q, cpu_addr);

  always_ff @(posedge clk) begin
    if (!rst_n)        held_addr <= '0;
    else if (start_rd) held_addr <= live_addr;
  end

  assign ext_addr = in_data ? held_addr : live_addr;

  // R6: a read's address does not move between its two cycles
  a_r6_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    start_rd |=> $stable(ext_addr));
endmodule

// File: rtl/bankwin_top.sv
module bankwin_top #(
  parameter int CPU_AW = 16,
  parameter int EXT_AW = 19,
  parameter int DW     = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CPU_AW-1:0]      cpu_addr,
  input  logic                   cpu_rd,
  input  logic                   cpu_wr,
  input  logic [DW-1:0]          cpu_wdata,
  output logic [DW-1:0]          cpu_rdata,
  output logic                   cpu_wait,
  input  logic                   bank_we,
  input  logic [EXT_AW-CPU_AW:0] bank_wdata,
  output logic                   int_sel,
  output logic [EXT_AW-1:0]      ext_addr,
  output logic                   ext_sel,
  output logic                   ext_rd,
  output logic                   ext_wr,
  output logic [DW-1:0]          ext_wdata,
  input  logic [DW-1:0]          ext_rdata
);
  localparam int BANK_W = EXT_AW - CPU_AW + 1;

  logic              win;
  logic              req_rd;
  logic              start_rd;
  logic              in_data;
  logic              idle_acc;
  logic [BANK_W-1:0] bank_q;

  assign win      = cpu_addr[CPU_AW-1];
  assign idle_acc = !in_data && (cpu_rd || cpu_wr);
  assign req_rd   = cpu_rd && !cpu_wr && win;

  bankwin_bank #(.BANK_W(BANK_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(bank_we), .wdata(bank_wdata), .bank_q(bank_q)
  );

  bankwin_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .start_rd(start_rd), .in_data(in_data)
  );

  bankwin_amux #(.CPU_AW(CPU_AW), .EXT_AW(EXT_AW)) u_amux (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .bank_q(bank_q),
    .start_rd(start_rd), .in_data(in_data), .ext_addr(ext_addr)
  );

  assign int_sel   = idle_acc && !win;
  assign ext_sel   = (idle_acc && win) || in_data;
  assign ext_wr    = !in_data && cpu_wr && win;
  assign ext_rd    = start_rd || in_data;
  assign cpu_wait  = start_rd;
  assign ext_wdata = cpu_wdata;
  assign cpu_rdata = in_data ? ext_rdata : '0;

  // R3: internal accesses never select the external device
  a_r3_low_internal: assert property (@(posedge clk) disable iff (!rst_n)
    int_sel |-> !ext_sel);
  // R4: writes never stall
  a_r4_wr_nowait: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr |-> !cpu_wait);
  // R5: a wait cycle is followed by a data cycle without wait
  a_r5_wait_then_data: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wait |=> (ext_rd && !cpu_wait));
  // R2: nothing external is strobed without chip select
  a_r2_strobe_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rd || ext_wr) |-> ext_sel);
endmodule

// File: tb/sim_bankwin_top.sv
module sim_bankwin_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        cpu_rd, cpu_wr;
  logic [7:0]  cpu_wdata, cpu_rdata;
  logic        cpu_wait;
  logic        bank_we;
  logic [3:0]  bank_wdata;
  logic        int_sel;
  logic [18:0] ext_addr;
  logic        ext_sel, ext_rd, ext_wr;
  logic [7:0]  ext_wdata;
  logic [7:0]  ext_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench-side external SRAM and the model's own view of memory
  logic [7:0] sram [int unsigned];
  logic [7:0] mmem [int unsigned];
  int unsigned mbank;
  bit          mdata;
  int unsigned mlat;

  always #5 clk = ~clk;

  bankwin_top u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_wait(cpu_wait),
    .bank_we(bank_we), .bank_wdata(bank_wdata), .int_sel(int_sel),
    .ext_addr(ext_addr), .ext_sel(ext_sel), .ext_rd(ext_rd), .ext_wr(ext_wr),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
  );

  task automatic chk(input string req, input string what, input int unsigned act,
                     input int unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // one CPU cycle: drive after the falling edge, compare 4 ns later, update model at the rise
  task automatic cyc(input string req, input bit rd, input bit wr, input int unsigned a,
                     input int unsigned wd, input bit bwe, input int unsigned bd);
    bit win;
    int unsigned e_addr;
    bit e_sel, e_rd, e_wr, e_int, e_wait;
    int unsigned e_rdata;
    @(negedge clk);
    cpu_rd = rd; cpu_wr = wr; cpu_addr = a[15:0]; cpu_wdata = wd[7:0];
    bank_we = bwe; bank_wdata = bd[3:0];
    #1;
    ext_rdata = sram.exists(ext_addr) ? sram[ext_addr] : 8'h00;
    #3;
    win = a[15];
    if (mdata) begin
      e_addr = mlat; e_sel = 1; e_rd = 1; e_wr = 0; e_int = 0; e_wait = 0;
      e_rdata = mmem.exists(mlat) ? mmem[mlat] : 0;
    end else begin
      e_addr  = mbank * 32768 + (a % 32768);
      e_int   = (rd || wr) && !win;
      e_sel   = (rd || wr) && win;
      e_wr    = wr && win;
      e_rd    = rd && !wr && win;
      e_wait  = e_rd;
      e_rdata = 0;
    end
    chk(req, "ext_addr", ext_addr, e_addr);
    chk(req, "ext_sel", ext_sel, e_sel);
    chk(req, "ext_rd", ext_rd, e_rd);
    chk(req, "ext_wr", ext_wr, e_wr);
    chk(req, "int_sel", int_sel, e_int);
    chk(req, "cpu_wait", cpu_wait, e_wait);
    chk(req, "cpu_rdata", cpu_rdata, e_rdata);
    if (e_wr) chk(req, "ext_wdata", ext_wdata, wd);
    // external device acts on its strobes
    if (ext_sel && ext_wr) sram[ext_addr] = ext_wdata;
    // model update
    if (mdata) mdata = 0;
    else if (e_rd) begin mdata = 1; mlat = e_addr; end
    if (!mdata && e_wr) mmem[e_addr] = wd[7:0];
    if (bwe) mbank = bd;
    @(posedge clk);
  endtask

  task automatic rd2(input string req, input int unsigned a);
    cyc(req, 1, 0, a, 0, 0, 0);
    cyc(req, 1, 0, a, 0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cpu_rd = 0; cpu_wr = 0; cpu_addr = 0; cpu_wdata = 0;
    bank_we = 0; bank_wdata = 0; ext_rdata = 0;
    mbank = 0; mdata = 0; mlat = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #4;
    chk("R1", "reset cpu_wait", cpu_wait, 0);
    chk("R1", "reset ext_sel", ext_sel, 0);
    @(negedge clk); rst_n = 1;

    // R1: bank 0 after reset
    cyc("R1", 0, 1, 16'h8000, 8'h11, 0, 0);
    rd2("R1", 16'h8000);
    // R3: lower half stays internal
    cyc("R3", 1, 0, 16'h1234, 0, 0, 0);
    cyc("R3", 0, 1, 16'h7FFF, 8'h99, 0, 0);
    // R8: idle cycle returns no data
    cyc("R8", 0, 0, 16'h8000, 0, 0, 0);
    // R6/R2: bank load, then write and read in bank 5
    cyc("R6", 0, 0, 16'h0000, 0, 1, 5);
    cyc("R2", 0, 1, 16'h8ABC, 8'h5A, 0, 0);
    rd2("R2", 16'h8ABC);
    // R7: bank write together with external write uses old bank
    cyc("R7", 0, 1, 16'hFFFF, 8'h77, 1, 9);
    rd2("R7", 16'hFFFF);
    cyc("R7", 0, 0, 16'h0000, 0, 1, 5);
    rd2("R7", 16'hFFFF);
    // R6: bank change during a read's first cycle does not move the read
    cyc("R6", 1, 0, 16'h8ABC, 0, 1, 2);
    cyc("R6", 1, 0, 16'h8ABC, 0, 0, 0);
    rd2("R6", 16'h8ABC);
    // R4: write wins over read requested together, no wait
    cyc("R4", 1, 1, 16'h9000, 8'h3C, 0, 0);
    rd2("R4", 16'h9000);
    // R10: top of the external space
    cyc("R10", 0, 0, 16'h0000, 0, 1, 15);
    cyc("R10", 0, 1, 16'hFFFF, 8'hE1, 0, 0);
    rd2("R10", 16'hFFFF);
    // R9: held read request restarts reads
    repeat (4) cyc("R9", 1, 0, 16'hFFFF, 0, 0, 0);
    // R5/R2: pattern across every bank, then read back
    for (int b = 0; b < 16; b++) begin
      cyc("R2", 0, 0, 0, 0, 1, b);
      cyc("R2", 0, 1, 16'h8000 + b * 3, (b ^ 8'hA5), 0, 0);
    end
    for (int b = 15; b >= 0; b--) begin
      cyc("R5", 0, 0, 0, 0, 1, b);
      rd2("R5", 16'h8000 + b * 3);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule